// File: doc/BRIEF.md
# Latched 64-bit System Timer with Match Channels

A free-running 64-bit up-counter, advanced by a programmable prescaler, sits behind a small 32-bit register bus. Six 32-bit match channels watch the low word of the counter. When the low word steps onto a channel's value, that channel's status flag is raised. Each flag stays set until software writes a one to it. A per-channel enable mask gates the flags onto one level-sensitive interrupt line.

Channel 5 can double as a watchdog. When its enable bit is set, a pending channel-5 flag drives a reset-request output.

Software reads a coherent 64-bit time by writing a snapshot command. This copies both counter halves into a pair of shadow registers in one cycle, and software then reads the shadows. Both live counter halves can be written, to zero the count or restore it after a power transition.

Top module: `tick64_timer`

## Requirements
- R1: Reset clears the counter, match values, status, enables, watchdog enable, divider, shadow registers, `irq` and `wdog_req`.
- R2: The prescaler pulses once every 2*(divider+1) clock cycles. The divider is taken from the 16-bit register at byte 0x2C. On each pulse the 64-bit counter adds one, with the carry passing from the low word into the high word.
- R3: A write to the counter low word (0x00) or high word (0x04) loads that half on the next edge and cancels any increment of that half. If only the high word is written on a pulse, the low word still increments. A low-word write suppresses the carry into the high word.
- R4: On a pulse where the low word increments, channel n (match register at 0x08+4n) fires when the incremented low word equals its match value. This also holds across the wrap from 0xFFFFFFFF to 0. Firing sets status bit n whether or not the channel is enabled.
- R5: Writing the status register (0x20) clears each bit written as 1 and leaves each bit written as 0 unchanged. A firing in the same cycle wins over the clear.
- R6: `irq` equals the OR over channels of (status AND enable), registered. It therefore changes one cycle after the status or enable register (0x24, bit n for channel n) changes.
- R7: Writing 0x30 with bit 0 set copies the whole 64-bit count present in that cycle into the shadow registers (low at 0x34, high at 0x38). A write with bit 0 clear does not change them. Address 0x30 reads as zero.
- R8: `wdog_req` equals, registered, watchdog enable (bit 0 at 0x28) AND status bit 5.
- R9: Every register listed above reads back at its byte offset. Unwritten upper bits and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined match interrupt level |
| wdog_req | output | 1 | Watchdog reset request |

## Verification
The bench preloads the counter just below the low-word wrap and places matches on both sides of it. A comparator that used magnitude rather than equality, or that lost the carry, would fire early, late or never.

Status writes that coincide with a firing check that set beats clear. A design with the priority reversed would drop an event. Counter writes landing on prescaler pulses check that a low-word write blocks the high-word carry. They also check that a high-word write leaves the low increment in place.

Snapshot commands with bit 0 clear must leave the shadows alone. An off-by-one prescaler shows up as drift against the bench's cycle-exact model.

// File: rtl/tick64_pkg.sv
package tick64_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_MATCH = 6;
  localparam int unsigned WDOG_IDX  = NUM_MATCH - 1;
  localparam int unsigned ADDR_W    = 6;

  // word indices (byte offset / 4)
  localparam logic [3:0] IDX_CNT_LO = 4'd0;
  localparam logic [3:0] IDX_CNT_HI = 4'd1;
  localparam logic [3:0] IDX_MATCH0 = 4'd2;
  localparam logic [3:0] IDX_STATUS = 4'd8;
  localparam logic [3:0] IDX_IEN    = 4'd9;
  localparam logic [3:0] IDX_WDEN   = 4'd10;
  localparam logic [3:0] IDX_DIV    = 4'd11;
  localparam logic [3:0] IDX_SNAP   = 4'd12;
  localparam logic [3:0] IDX_SHD_LO = 4'd13;
  localparam logic [3:0] IDX_SHD_HI = 4'd14;
endpackage

// File: rtl/tick64_prescaler.sv
module tick64_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divider,
  output logic             tick
);
  localparam int unsigned PC_W = DIV_W + 1;

  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] limit;

  always_comb begin
    limit = {divider, 1'b1};
    tick  = (pc_q >= limit);
    pc_d  = tick ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/tick64_counter.sv
module tick64_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         step,
  output logic [W-1:0] step_lo
);
  logic [W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic         carry;

  always_comb begin
    step    = tick && !wr_lo;
    step_lo = lo_q + 1'b1;
    carry   = step && (lo_q == '1);
    lo_d    = lo_q;
    hi_d    = hi_q;
    if (wr_lo)     lo_d = wdata;
    else if (tick) lo_d = step_lo;
    if (wr_hi)      hi_d = wdata;
    else if (carry) hi_d = hi_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_lo = lo_q;
  assign cnt_hi = hi_q;
endmodule

// File: rtl/tick64_match.sv
module tick64_match #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 6
) (
  input  logic              step,
  input  logic [W-1:0]      step_lo,
  input  logic [N-1:0][W-1:0] match_val,
  output logic [N-1:0]      hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = step && (step_lo == match_val[g]);
  end
endmodule

// File: rtl/tick64_timer.sv
module tick64_timer
  import tick64_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq,
  output logic              wdog_req
);
  localparam int unsigned N = NUM_MATCH;

  logic [3:0] widx;
  assign widx = bus_addr[5:2];

  logic [N-1:0][WORD_W-1:0] match_q, match_d;
  logic [N-1:0]  status_q, status_d, ien_q, ien_d, hit, clr_mask;
  logic          wden_q, wden_d, irq_q, irq_d, wdog_q, wdog_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [WORD_W-1:0] shd_lo_q, shd_lo_d, shd_hi_q, shd_hi_d;
  logic [WORD_W-1:0] cnt_lo, cnt_hi, step_lo;
  logic          tick, step, wr_lo, wr_hi, snap_en;

  assign wr_lo   = bus_we && (widx == IDX_CNT_LO);
  assign wr_hi   = bus_we && (widx == IDX_CNT_HI);
  assign snap_en = bus_we && (widx == IDX_SNAP) && bus_wdata[0];

  tick64_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .divider(div_q), .tick(tick)
  );

  tick64_counter #(.W(WORD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .step(step), .step_lo(step_lo)
  );

  tick64_match #(.W(WORD_W), .N(N)) u_match (
    .step(step), .step_lo(step_lo), .match_val(match_q), .hit(hit)
  );

  // next-state logic
  always_comb begin
    match_d  = match_q;
    ien_d    = ien_q;
    wden_d   = wden_q;
    div_d    = div_q;
    shd_lo_d = shd_lo_q;
    shd_hi_d = shd_hi_q;
    clr_mask = '0;
    if (bus_we) begin
      for (int i = 0; i < N; i++) begin
        if (widx == IDX_MATCH0 + 4'(i)) match_d[i] = bus_wdata;
      end
      if (widx == IDX_STATUS) clr_mask = bus_wdata[N-1:0];
      if (widx == IDX_IEN)    ien_d    = bus_wdata[N-1:0];
      if (widx == IDX_WDEN)   wden_d   = bus_wdata[0];
      if (widx == IDX_DIV)    div_d    = bus_wdata[DIV_W-1:0];
    end
    if (snap_en) begin
      shd_lo_d = cnt_lo;
      shd_hi_d = cnt_hi;
    end
    status_d = (status_q & ~clr_mask) | hit;
    irq_d    = |(status_q & ien_q);
    wdog_d   = wden_q && status_q[WDOG_IDX];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q  <= '0;
      status_q <= '0;
      ien_q    <= '0;
      wden_q   <= 1'b0;
      div_q    <= '0;
      shd_lo_q <= '0;
      shd_hi_q <= '0;
      irq_q    <= 1'b0;
      wdog_q   <= 1'b0;
    end else begin
      match_q  <= match_d;
      status_q <= status_d;
      ien_q    <= ien_d;
      wden_q   <= wden_d;
      div_q    <= div_d;
      shd_lo_q <= shd_lo_d;
      shd_hi_q <= shd_hi_d;
      irq_q    <= irq_d;
      wdog_q   <= wdog_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (widx)
      IDX_CNT_LO: bus_rdata = cnt_lo;
      IDX_CNT_HI: bus_rdata = cnt_hi;
      IDX_STATUS: bus_rdata = WORD_W'(status_q);
      IDX_IEN:    bus_rdata = WORD_W'(ien_q);
      IDX_WDEN:   bus_rdata = WORD_W'(wden_q);
      IDX_DIV:    bus_rdata = WORD_W'(div_q);
      IDX_SHD_LO: bus_rdata = shd_lo_q;
      IDX_SHD_HI: bus_rdata = shd_hi_q;
      default: begin
        for (int i = 0; i < N; i++) begin
          if (widx == IDX_MATCH0 + 4'(i)) bus_rdata = match_q[i];
        end
      end
    endcase
  end

  assign irq      = irq_q;
  assign wdog_req = wdog_q;
endmodule

// File: rtl/tick64_timer_checker.sv
module tick64_timer_checker
  import tick64_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [NUM_MATCH-1:0] status_q,
  input logic [NUM_MATCH-1:0] ien_q,
  input logic              wden_q,
  input logic [WORD_W-1:0] cnt_lo,
  input logic [WORD_W-1:0] cnt_hi,
  input logic [WORD_W-1:0] shd_lo_q,
  input logic [WORD_W-1:0] shd_hi_q,
  input logic              irq,
  input logic              wdog_req
);
  logic wr_cnt, wr_stat, snap;
  assign wr_cnt  = bus_we && (bus_addr[5:3] == 3'd0);
  assign wr_stat = bus_we && (bus_addr[5:2] == IDX_STATUS);
  assign snap    = bus_we && (bus_addr[5:2] == IDX_SNAP) && bus_wdata[0];

  // R2: without a pulse or a write the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  // R5: a clear with no pulse leaves the written bits low
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !tick) |=> ((status_q & $past(bus_wdata[NUM_MATCH-1:0])) == '0));

  // R6: interrupt is the registered masked OR
  a_r6_irq: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status_q & ien_q))));

  // R7: snapshot copies the live count
  a_r7_snap: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (shd_lo_q == $past(cnt_lo) && shd_hi_q == $past(cnt_hi)));

  // R8: watchdog request only with enable and channel-5 flag
  a_r8_wdog: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_req) |-> $past(wden_q && status_q[WDOG_IDX]));
endmodule

bind tick64_timer tick64_timer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_q(status_q),
  .ien_q(ien_q), .wden_q(wden_q), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .shd_lo_q(shd_lo_q), .shd_hi_q(shd_hi_q), .irq(irq), .wdog_req(wdog_req)
);

// File: tb/tick64_timer_bench.sv
module tick64_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wdog_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit mon_on = 0;

  always #2.5 clk = ~clk;

  tick64_timer u_tick64_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdog_req(wdog_req)
  );

  // reference model built from the requirements
  logic [16:0] m_pc;
  logic [15:0] m_div;
  logic [31:0] m_lo, m_hi, m_slo, m_shi;
  logic [31:0] m_mt [6];
  logic [5:0]  m_st, m_ie;
  logic        m_wde, m_irq, m_wd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = '0; m_div = '0; m_lo = '0; m_hi = '0; m_slo = '0; m_shi = '0;
      for (int i = 0; i < 6; i++) m_mt[i] = '0;
      m_st = '0; m_ie = '0; m_wde = 0; m_irq = 0; m_wd = 0;
    end else begin
      logic t, wlo, whi, stp;
      logic [5:0] ev, clr;
      logic [31:0] nlo, nhi;
      t   = ({15'd0, m_pc} >= 32'(m_div) * 2 + 1);
      wlo = bus_we && bus_addr == 6'h00;
      whi = bus_we && bus_addr == 6'h04;
      stp = t && !wlo;
      for (int i = 0; i < 6; i++) ev[i] = stp && (m_lo + 32'd1 == m_mt[i]);  // R4
      nlo = wlo ? bus_wdata : (t ? m_lo + 32'd1 : m_lo);                       // R2 R3
      nhi = whi ? bus_wdata : m_hi + {31'd0, stp && m_lo == 32'hFFFF_FFFF};
      clr = (bus_we && bus_addr == 6'h20) ? bus_wdata[5:0] : 6'd0;
      m_irq = |(m_st & m_ie);                                                   // R6
      m_wd  = m_wde && m_st[5];                                                 // R8
      if (bus_we && bus_addr == 6'h30 && bus_wdata[0]) begin m_slo = m_lo; m_shi = m_hi; end  // R7
      m_st = (m_st & ~clr) | ev;                                                // R5
      if (bus_we) begin
        for (int i = 0; i < 6; i++) if (bus_addr == 6'(8 + 4*i)) m_mt[i] = bus_wdata;
        if (bus_addr == 6'h24) m_ie  = bus_wdata[5:0];
        if (bus_addr == 6'h28) m_wde = bus_wdata[0];
        if (bus_addr == 6'h2C) m_div = bus_wdata[15:0];
      end
      m_pc = t ? '0 : m_pc + 1'b1;
      m_lo = nlo; m_hi = nhi;
    end
  end

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_lo;
      6'h04: return m_hi;
      6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C: return m_mt[(a - 6'h08) >> 2];
      6'h20: return {26'd0, m_st};
      6'h24: return {26'd0, m_ie};
      6'h28: return {31'd0, m_wde};
      6'h2C: return {16'd0, m_div};
      6'h34: return m_slo;
      6'h38: return m_shi;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input string req);
    @(negedge clk); bus_we = 1'b0; bus_addr = a; #1;
    check(req, bus_rdata, m_read(a));
  endtask

  // R6 R8 continuous comparison of the output lines
  always @(negedge clk) begin
    if (mon_on) begin
      check("R6 irq", {31'd0, irq}, {31'd0, m_irq});
      check("R8 wdog_req", {31'd0, wdog_req}, {31'd0, m_wd});
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, R9 unmapped offset
    for (int a = 0; a < 64; a += 4) rd(6'(a), "R1 R9 reset readback");
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 wdog", {31'd0, wdog_req}, 32'd0);
    mon_on = 1;

    // R2: free run at divider 0 then divider 3
    repeat (20) @(negedge clk);
    rd(6'h00, "R2 count div0");
    wr(6'h2C, 32'd3);
    repeat (40) @(negedge clk);
    rd(6'h00, "R2 count div3");
    wr(6'h2C, 32'd0);

    // R4: wrap crossing with matches on both sides, R3 R2 carry
    wr(6'h04, 32'h0000_0007);
    wr(6'h00, 32'hFFFF_FFF8);
    wr(6'h08, 32'hFFFF_FFFC);
    wr(6'h0C, 32'h0000_0003);
    wr(6'h24, 32'h0000_0002);
    repeat (40) @(negedge clk);
    rd(6'h20, "R4 status after wrap");
    rd(6'h04, "R2 carry into high");
    // R5: clear only channel 0, write 0 leaves bits
    wr(6'h20, 32'h0);
    rd(6'h20, "R5 zero write");
    wr(6'h20, 32'h1);
    rd(6'h20, "R5 clear bit0");
    wr(6'h20, 32'h3F);
    rd(6'h20, "R5 clear all");

    // R7: snapshot with bit0 clear then set
    wr(6'h30, 32'hFFFF_FFFE);
    rd(6'h34, "R7 no snapshot lo");
    wr(6'h30, 32'h1);
    rd(6'h34, "R7 snapshot lo");
    rd(6'h38, "R7 snapshot hi");
    rd(6'h30, "R7 command reads zero");

    // R8: watchdog channel
    wr(6'h28, 32'h1);
    rd(6'h00, "R9 live low");
    wr(6'h1C, m_lo + 32'd6);
    repeat (20) @(negedge clk);
    check("R8 wdog asserted", {31'd0, wdog_req}, 32'd1);
    wr(6'h20, 32'h20);
    repeat (3) @(negedge clk);
    check("R8 wdog released", {31'd0, wdog_req}, 32'd0);

    // random mix, R3 collisions with pulses
    for (int it = 0; it < 4000; it++) begin
      int unsigned sel;
      logic [31:0] d;
      sel = $urandom_range(0, 99);
      d = $urandom();
      if (sel < 8)       wr(6'h00, (sel < 4) ? 32'hFFFF_FFF0 + (d & 32'hF) : d);
      else if (sel < 12) wr(6'h04, d);
      else if (sel < 30) wr(6'(8 + 4 * $urandom_range(0, 5)), m_lo + (d & 32'h1F));
      else if (sel < 38) wr(6'h20, d);
      else if (sel < 44) wr(6'h24, d);
      else if (sel < 47) wr(6'h28, d);
      else if (sel < 50) wr(6'h2C, d & 32'h3);
      else if (sel < 58) wr(6'h30, d);
      else if (sel < 85) rd(6'(4 * $urandom_range(0, 15)), "R3 R4 R9 random readback");
      else               @(negedge clk);
    end
    for (int a = 0; a < 64; a += 4) rd(6'(a), "R9 final readback");

    mon_on = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule